// File: doc/BRIEF.md
# Serial Command Decoder for a Digital Potentiometer

This block is the serial slave front end of a digitally controlled resistor. It watches a four-wire serial link (select, clock, data in, data out) plus a pause input. It oversamples every pin in the system clock domain. It takes in a frame that opens with an identification byte and then an instruction byte. Out of that frame it produces single-cycle request strobes for the wiper register and the register bank that sit beside it. The analog switch array and the nonvolatile storage live elsewhere. This block only works out what the host asked for and when.

Each request carries the register pointer and the bank pointer, and for writes it also carries the data byte. For reads, the block asks its neighbour for the value with a request strobe. It then expects the answer on `rd_data` and shifts that byte back to the host on the data-out line. A status read instead returns the externally supplied write-in-progress flag. The increment/decrement frame has no fixed length: every further clock edge becomes one step request, whose direction is taken from the data-in line.

Top module: `dpot_cmd_decoder`

## Requirements
- R1: The first byte after select falls must be 0101 in bits 7:4 and 00 in bits 3:2. Bits 1:0 must equal `addr_pins`. Otherwise no request is made and the rest of the frame is ignored until select rises.
- R2: The second byte carries an opcode in bits 7:4, a register pointer in bits 3:2 and a bank pointer in bits 1:0. The opcodes map to `req_op` codes as follows: 1001→1 read wiper, 1010→2 write wiper, 1011→3 read register, 1100→4 write register, 1101→5 register to wiper, 1110→6 wiper to register, 0010→7 step, 0101→8 status. `req_reg` and `req_bank` echo the two pointers.
- R3: An opcode outside that list is dropped silently. So are the wiper-touching operations (codes 1, 2, 5, 6, 7) when the bank pointer is nonzero.
- R4: Codes 1, 3 and 8 strobe once after the second byte. The third byte then goes out on `so`, MSB first, and changes only on falling serial clock edges. For code 1 and code 3 that byte is `rd_data`. For code 8 it is seven zeros followed by `wip` in the LSB.
- R5: Codes 2 and 4 strobe once after the third byte. `req_data` holds that byte, sampled MSB first on rising serial clock edges.
- R6: Codes 5 and 6 strobe once after the second byte. Any further bytes in the same frame produce nothing.
- R7: After a code 7 instruction, every rising serial clock edge makes one step request until select rises. `req_up` equals the data-in level at that edge.
- R8: `so_oe` is high only during the data byte of a read frame. It is low whenever select is high or the link is paused.
- R9: Pulling `hold_n` low while the serial clock is low pauses the frame. Raising it while the clock is low resumes the frame at the same bit. Clock edges during the pause are ignored.
- R10: After reset, no request is made until select has gone from high to low.
- R11: Select rising at any point abandons the frame. The next frame is decoded from its identification byte.
- R12: Every request is a strobe of exactly one system clock cycle, and there is one strobe per decoded event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data from host |
| hold_n | input | 1 | Pause input, active low |
| addr_pins | input | 2 | Strapped slave address |
| wip | input | 1 | Write-in-progress flag returned by status reads |
| rd_data | input | BYTE_W | Read value supplied after a read request |
| so | output | 1 | Serial data to host |
| so_oe | output | 1 | Output enable for `so` (low means high impedance) |
| req_valid | output | 1 | One-cycle request strobe |
| req_op | output | 4 | Request code, see R2 |
| req_reg | output | 2 | Register pointer |
| req_bank | output | 2 | Bank pointer |
| req_data | output | BYTE_W | Write data |
| req_up | output | 1 | Step direction, 1 toward the high end |

## Verification
The assertions are checked on every cycle. They cover the following: no wiper-touching strobe ever carries a nonzero bank, strobes never last two cycles, select high always returns the parser to idle, the output line moves only on falling clock edges, and the output enable stays low through a pause. Other behaviour can only be shown by the bench's scenarios. This includes whether each opcode maps to the right request, whether a read returns the right byte, whether a foreign address or a select without a prior falling edge is ignored, and whether a pause with stray clock edges resumes at the right bit.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int OPC_W = 4;
  localparam int PTR_W = 2;

  typedef enum logic [3:0] {
    OP_NONE      = 4'd0,
    OP_RD_WIPER  = 4'd1,
    OP_WR_WIPER  = 4'd2,
    OP_RD_REG    = 4'd3,
    OP_WR_REG    = 4'd4,
    OP_REG2WIPER = 4'd5,
    OP_WIPER2REG = 4'd6,
    OP_STEP      = 4'd7,
    OP_STATUS    = 4'd8
  } req_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ID, S_INSTR, S_WDATA, S_RDATA, S_STEP, S_SKIP
  } frame_st_e;

  function automatic req_op_e decode_opcode(input logic [OPC_W-1:0] opc);
    case (opc)
      4'b1001: return OP_RD_WIPER;
      4'b1010: return OP_WR_WIPER;
      4'b1011: return OP_RD_REG;
      4'b1100: return OP_WR_REG;
      4'b1101: return OP_REG2WIPER;
      4'b1110: return OP_WIPER2REG;
      4'b0010: return OP_STEP;
      4'b0101: return OP_STATUS;
      default: return OP_NONE;
    endcase
  endfunction

  function automatic logic touches_wiper(input req_op_e op);
    return op inside {OP_RD_WIPER, OP_WR_WIPER, OP_REG2WIPER, OP_WIPER2REG, OP_STEP};
  endfunction
endpackage

// File: rtl/dpot_pin_sync.sv
module dpot_pin_sync (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  output logic cs_hi,
  output logic cs_fall,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_s,
  output logic paused
);
  logic cs_r, cs_d, sck_r, sck_d, hold_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_r   <= 1'b0;
      cs_d   <= 1'b0;
      sck_r  <= 1'b0;
      sck_d  <= 1'b0;
      si_s   <= 1'b0;
      hold_r <= 1'b1;
      paused <= 1'b0;
    end else begin
      cs_r   <= cs_n;
      cs_d   <= cs_r;
      sck_r  <= sck;
      sck_d  <= sck_r;
      si_s   <= si;
      hold_r <= hold_n;
      if (cs_r)        paused <= 1'b0;
      else if (!sck_r) paused <= !hold_r;
    end
  end

  assign cs_hi    = cs_r;
  assign cs_fall  = cs_d & !cs_r;
  assign sck_rise = sck_r & !sck_d & !paused & !cs_r;
  assign sck_fall = !sck_r & sck_d & !paused & !cs_r;
endmodule

// File: rtl/dpot_frame_fsm.sv
module dpot_frame_fsm
  import dpot_pkg::*;
#(
  parameter int          BYTE_W  = 8,
  parameter logic [3:0]  ID_CODE = 4'b0101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_hi,
  input  logic              cs_fall,
  input  logic              sck_rise,
  input  logic              si_s,
  input  logic [PTR_W-1:0]  addr,
  output logic              req_valid,
  output req_op_e           req_op,
  output logic [PTR_W-1:0]  req_reg,
  output logic [PTR_W-1:0]  req_bank,
  output logic [BYTE_W-1:0] req_data,
  output logic              req_up,
  output logic              tx_load,
  output logic              tx_status,
  output logic              out_phase
);
  localparam int CNT_W = $clog2(BYTE_W);

  frame_st_e          state;
  logic [CNT_W-1:0]   cnt;
  logic [BYTE_W-2:0]  rx;
  req_op_e            op_q;
  logic [PTR_W-1:0]   reg_q, bank_q;

  logic [BYTE_W-1:0]  byte_w;
  logic               done, id_ok, instr_ok;
  req_op_e            instr_op;

  assign byte_w = {rx, si_s};
  assign done   = (cnt == CNT_W'(BYTE_W-1));

  always_comb begin
    id_ok = (byte_w[BYTE_W-1 -: 4] == ID_CODE) &&
            (byte_w[BYTE_W-5:2*PTR_W-2] == '0) &&
            (byte_w[PTR_W-1:0] == addr);
    instr_op = decode_opcode(byte_w[BYTE_W-1 -: OPC_W]);
    instr_ok = (instr_op != OP_NONE) &&
               !(touches_wiper(instr_op) && (byte_w[PTR_W-1:0] != '0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cnt       <= '0;
      rx        <= '0;
      op_q      <= OP_NONE;
      reg_q     <= '0;
      bank_q    <= '0;
      req_valid <= 1'b0;
      req_op    <= OP_NONE;
      req_reg   <= '0;
      req_bank  <= '0;
      req_data  <= '0;
      req_up    <= 1'b0;
      tx_load   <= 1'b0;
      tx_status <= 1'b0;
    end else begin
      req_valid <= 1'b0;
      tx_load   <= 1'b0;
      if (cs_hi) begin
        state <= S_IDLE;
        cnt   <= '0;
      end else if (cs_fall) begin
        state <= S_ID;
        cnt   <= '0;
      end else if (sck_rise) begin
        rx  <= byte_w[BYTE_W-2:0];
        cnt <= done ? '0 : cnt + 1'b1;
        if (state == S_STEP) begin
          req_valid <= 1'b1;
          req_op    <= OP_STEP;
          req_reg   <= reg_q;
          req_bank  <= bank_q;
          req_up    <= si_s;
        end else if (done) begin
          case (state)
            S_ID: state <= id_ok ? S_INSTR : S_SKIP;
            S_INSTR: begin
              op_q   <= instr_op;
              reg_q  <= byte_w[2*PTR_W-1 -: PTR_W];
              bank_q <= byte_w[PTR_W-1:0];
              if (!instr_ok) begin
                state <= S_SKIP;
              end else begin
                case (instr_op)
                  OP_WR_WIPER, OP_WR_REG: state <= S_WDATA;
                  OP_STEP:                state <= S_STEP;
                  default: begin
                    req_valid <= 1'b1;
                    req_op    <= instr_op;
                    req_reg   <= byte_w[2*PTR_W-1 -: PTR_W];
                    req_bank  <= byte_w[PTR_W-1:0];
                    if (instr_op inside {OP_RD_WIPER, OP_RD_REG, OP_STATUS}) begin
                      tx_load   <= 1'b1;
                      tx_status <= (instr_op == OP_STATUS);
                      state     <= S_RDATA;
                    end else begin
                      state <= S_SKIP;
                    end
                  end
                endcase
              end
            end
            S_WDATA: begin
              req_valid <= 1'b1;
              req_op    <= op_q;
              req_reg   <= reg_q;
              req_bank  <= bank_q;
              req_data  <= byte_w;
              state     <= S_SKIP;
            end
            S_RDATA: state <= S_SKIP;
            default: ;
          endcase
        end
      end
    end
  end

  assign out_phase = (state == S_RDATA);

  assert_wiper_bank0_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && touches_wiper(req_op)) |-> (req_bank == '0));

  assert_single_strobe_R12: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid);

  assert_cs_abort_R11: assert property (@(posedge clk) disable iff (rst)
    cs_hi |=> (state == S_IDLE));
endmodule

// File: rtl/dpot_so_shift.sv
module dpot_so_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_hi,
  input  logic              paused,
  input  logic              sck_fall,
  input  logic              load,
  input  logic              load_status,
  input  logic [BYTE_W-1:0] rd_data,
  input  logic              wip,
  input  logic              out_phase,
  output logic              so,
  output logic              so_oe
);
  logic [BYTE_W-1:0] tx;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx    <= '0;
      so    <= 1'b0;
      so_oe <= 1'b0;
    end else begin
      so_oe <= out_phase & !cs_hi & !paused;
      if (load) begin
        tx <= load_status ? {{(BYTE_W-1){1'b0}}, wip} : rd_data;
      end else if (sck_fall && out_phase) begin
        so <= tx[BYTE_W-1];
        tx <= {tx[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assert_so_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
    !sck_fall |=> $stable(so));
endmodule

// File: rtl/dpot_cmd_decoder.sv
module dpot_cmd_decoder
  import dpot_pkg::*;
#(
  parameter int         BYTE_W  = 8,
  parameter logic [3:0] ID_CODE = 4'b0101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              hold_n,
  input  logic [1:0]        addr_pins,
  input  logic              wip,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              so,
  output logic              so_oe,
  output logic              req_valid,
  output logic [3:0]        req_op,
  output logic [1:0]        req_reg,
  output logic [1:0]        req_bank,
  output logic [BYTE_W-1:0] req_data,
  output logic              req_up
);
  logic    cs_hi, cs_fall, sck_rise, sck_fall, si_s, paused;
  logic    tx_load, tx_status, out_phase;
  req_op_e op_s;

  dpot_pin_sync u_sync (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .cs_hi(cs_hi), .cs_fall(cs_fall), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .si_s(si_s), .paused(paused)
  );

  dpot_frame_fsm #(.BYTE_W(BYTE_W), .ID_CODE(ID_CODE)) u_fsm (
    .clk(clk), .rst(rst), .cs_hi(cs_hi), .cs_fall(cs_fall), .sck_rise(sck_rise),
    .si_s(si_s), .addr(addr_pins), .req_valid(req_valid), .req_op(op_s),
    .req_reg(req_reg), .req_bank(req_bank), .req_data(req_data), .req_up(req_up),
    .tx_load(tx_load), .tx_status(tx_status), .out_phase(out_phase)
  );

  dpot_so_shift #(.BYTE_W(BYTE_W)) u_so (
    .clk(clk), .rst(rst), .cs_hi(cs_hi), .paused(paused), .sck_fall(sck_fall),
    .load(tx_load), .load_status(tx_status), .rd_data(rd_data), .wip(wip),
    .out_phase(out_phase), .so(so), .so_oe(so_oe)
  );

  assign req_op = op_s;

  assert_pause_hiz_R8: assert property (@(posedge clk) disable iff (rst)
    (paused && $past(paused)) |-> !so_oe);
endmodule

// File: tb/dpot_cmd_decoder_tb.sv
module dpot_cmd_decoder_tb;
  localparam int HALF = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b0, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wip = 1'b0;
  logic [1:0] addr_pins = 2'b00;
  logic [7:0] rd_data = 8'h00;
  logic so, so_oe, req_valid, req_up;
  logic [3:0] req_op;
  logic [1:0] req_reg, req_bank;
  logic [7:0] req_data;

  int checks = 0, failures = 0;
  int mon_cnt = 0;
  logic [3:0] m_op; logic [1:0] m_reg, m_bank; logic [7:0] m_data;
  logic [63:0] ups;

  always #5 clk = ~clk;

  dpot_cmd_decoder u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .addr_pins(addr_pins), .wip(wip), .rd_data(rd_data), .so(so), .so_oe(so_oe),
    .req_valid(req_valid), .req_op(req_op), .req_reg(req_reg), .req_bank(req_bank),
    .req_data(req_data), .req_up(req_up)
  );

  always @(negedge clk) begin
    if (!rst && req_valid) begin
      m_op = req_op; m_reg = req_reg; m_bank = req_bank; m_data = req_data;
      ups[mon_cnt[5:0]] = req_up;
      mon_cnt = mon_cnt + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_op(input logic [3:0] opc, input logic [1:0] bank);
    int c;
    case (opc)
      4'b1001: c = 1; 4'b1010: c = 2; 4'b1011: c = 3; 4'b1100: c = 4;
      4'b1101: c = 5; 4'b1110: c = 6; 4'b0010: c = 7; 4'b0101: c = 8;
      default: c = 0;
    endcase
    if (bank != 2'b00 && (c == 1 || c == 2 || c == 5 || c == 6 || c == 7)) c = 0;
    return c;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer_bit(input logic b, output logic r);
    si = b;
    wait_clk(HALF);
    r = so;
    sck = 1'b1;
    wait_clk(HALF);
    sck = 1'b0;
  endtask

  task automatic xfer_byte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      logic x;
      xfer_bit(b[i], x);
      r[i] = x;
    end
  endtask

  task automatic cs_begin();
    mon_cnt = 0; ups = '0;
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_end();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(3 * HALF);
  endtask

  task automatic pause_link(input logic expect_oe);
    hold_n = 1'b0;
    wait_clk(HALF);
    for (int k = 0; k < 2; k++) begin
      si = ~si; sck = 1'b1; wait_clk(HALF);
      sck = 1'b0; wait_clk(HALF);
    end
    chk("R9 so_oe low while paused", so_oe, 0);
    hold_n = 1'b1;
    wait_clk(HALF);
    chk("R8 so_oe after resume", so_oe, expect_oe);
  endtask

  task automatic run_frame(input logic [3:0] opc, input logic [1:0] rs, input logic [1:0] bs,
                           input logic [3:0] idt, input logic [1:0] ida,
                           input logic [7:0] dat, input logic [7:0] rdv, input logic w);
    logic [7:0] r;
    int e;
    rd_data = rdv; wip = w;
    e = (idt == 4'b0101 && ida == addr_pins) ? exp_op(opc, bs) : 0;
    cs_begin();
    xfer_byte({idt, 2'b00, ida}, r);
    xfer_byte({opc, rs, bs}, r);
    xfer_byte(dat, r);
    cs_end();
    chk("R8 so_oe low after frame", so_oe, 0);
    if (e == 0) begin
      chk("R1/R3 dropped frame count", mon_cnt, 0);
    end else if (e == 7) begin
      chk("R7 R12 step count", mon_cnt, 8);
      for (int i = 0; i < 8; i++) chk("R7 step direction", ups[i], dat[7-i]);
      chk("R2 step op", m_op, 7);
    end else begin
      chk("R12 one strobe", mon_cnt, 1);
      chk("R2 op code", m_op, e);
      chk("R2 reg ptr", m_reg, rs);
      chk("R2 bank ptr", m_bank, bs);
      if (e == 2 || e == 4) chk("R5 write data", m_data, dat);
      if (e == 1 || e == 3) chk("R4 read byte", r, rdv);
      if (e == 8) chk("R4 status byte", r, {7'b0, w});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic [3:0] opc_tab [10];
    opc_tab = '{4'b1001, 4'b1010, 4'b1011, 4'b1100, 4'b1101,
                4'b1110, 4'b0010, 4'b0101, 4'b0000, 4'b1111};
    void'($urandom(32'h5EED_0042));
    wait_clk(4);
    rst = 1'b0;
    wait_clk(2);
    chk("R8 reset so_oe", so_oe, 0);
    chk("R12 reset strobe", req_valid, 0);

    // R10: select held low since reset, no falling edge yet
    mon_cnt = 0;
    xfer_byte(8'b0101_0000, r);
    xfer_byte(8'b1010_0000, r);
    xfer_byte(8'h5A, r);
    wait_clk(HALF);
    chk("R10 no command before select falls", mon_cnt, 0);
    cs_n = 1'b1;
    wait_clk(3 * HALF);

    // R6: copy with trailing byte
    run_frame(4'b1101, 2'b10, 2'b00, 4'b0101, 2'b00, 8'hFF, 8'h00, 1'b0);
    // R3: copy with nonzero bank dropped, register write with bank allowed
    run_frame(4'b1110, 2'b01, 2'b11, 4'b0101, 2'b00, 8'h00, 8'h00, 1'b0);
    run_frame(4'b1100, 2'b11, 2'b10, 4'b0101, 2'b00, 8'hC3, 8'h00, 1'b0);
    // R4: status with flag set
    run_frame(4'b0101, 2'b00, 2'b01, 4'b0101, 2'b00, 8'h00, 8'hAA, 1'b1);

    // R11: abort mid-instruction, then a clean write
    cs_begin();
    xfer_byte(8'b0101_0000, r);
    for (int i = 0; i < 4; i++) begin logic x; xfer_bit(1'b1, x); end
    cs_end();
    chk("R11 aborted frame silent", mon_cnt, 0);
    run_frame(4'b1010, 2'b00, 2'b00, 4'b0101, 2'b00, 8'h3C, 8'h00, 1'b0);

    // R9: pause in the middle of a read data byte
    rd_data = 8'hB5;
    cs_begin();
    xfer_byte(8'b0101_0000, r);
    xfer_byte(8'b1011_0100, r);
    for (int i = 7; i >= 4; i--) begin logic x; xfer_bit(1'b0, x); r[i] = x; end
    chk("R8 so_oe in read phase", so_oe, 1);
    pause_link(1'b1);
    for (int i = 3; i >= 0; i--) begin logic x; xfer_bit(1'b0, x); r[i] = x; end
    cs_end();
    chk("R9 read byte across pause", r, 8'hB5);
    chk("R9 one read strobe", mon_cnt, 1);

    // R9: pause in a write data byte
    cs_begin();
    xfer_byte(8'b0101_0000, r);
    xfer_byte(8'b1100_0100, r);
    for (int i = 7; i >= 3; i--) begin logic x; xfer_bit(((8'h96 >> i) & 1) != 0, x); end
    pause_link(1'b0);
    for (int i = 2; i >= 0; i--) begin logic x; xfer_bit(((8'h96 >> i) & 1) != 0, x); end
    cs_end();
    chk("R9 write data across pause", m_data, 8'h96);

    // random frames
    for (int n = 0; n < 48; n++) begin
      logic [3:0] opc, idt;
      logic [1:0] rs, bs, ida;
      opc = opc_tab[$urandom % 10];
      rs  = 2'($urandom);
      bs  = ($urandom % 3 == 0) ? 2'($urandom) : 2'b00;
      addr_pins = 2'($urandom);
      idt = 4'b0101;
      ida = addr_pins;
      case ($urandom % 8)
        0: ida = ~addr_pins;
        1: idt = 4'($urandom) | 4'b1000;
        default: ;
      endcase
      run_frame(opc, rs, bs, idt, ida, 8'($urandom), 8'($urandom), 1'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule